// File: doc/BRIEF.md
# PCI Master Burst Command Selector

This block sits between a DMA engine and the master side of a PCI bus interface. When a new burst is about to begin, the DMA engine pulses a start strobe. The block then picks the PCI bus command and the burst length in Dwords for that burst. It bases the choice on the current configuration and transfer state. For writes it decides between a plain memory write and a write-and-invalidate. For reads it decides among plain memory read, read line and read multiple.

The block registers the chosen command and length when the strobe arrives. They stay frozen until the bus interface reports that the burst has ended. Only then does the block take a new strobe.

Inputs to the decision:
- five mode enables;
- the cache line size in Dwords;
- the programmed maximum burst in Dwords;
- the byte address;
- the bytes left in the transfer;
- the bytes held in the DMA FIFO.

A write that starts off a line boundary first runs a plain write up to that boundary. The write that follows can then be upgraded.

Top module: `pci_cmd_select`

## Requirements
- R1: While reset is asserted (rst_n low), and until the first accepted start, busy is 0, cmd is 0x0 and burst_dw is 0.
- R2: A start seen at a clock edge while busy is 0 makes busy 1 after that edge, with cmd and burst_dw loaded. While busy is 1 and done is 0, both outputs and busy hold their values whatever the other inputs do, including further start pulses.
- R3: A done seen at a clock edge while busy is 1 clears busy after that edge, and cmd and burst_dw keep their values.
- R4: A write gets cmd 0xF (write and invalidate) only if line_size_en, dev_inv_en and bus_inv_en are all 1. Otherwise a write gets cmd 0x7 (memory write).
- R5: Write and invalidate needs line_size_dw to be one of 2, 4, 8, 16, 32, 64 or 128.
- R6: Write and invalidate needs line_size_dw no greater than max_burst_dw.
- R7: Write and invalidate needs fifo_bytes/4 and remain_bytes/4 (floor) each to be at least line_size_dw.
- R8: Write and invalidate needs the Dword address addr/4 to be a multiple of line_size_dw. addr bits [1:0] play no part.
- R9: A 0xF burst length is min(A, M). A is min(remain_bytes/4, fifo_bytes/4) rounded down to whole lines. M is max_burst_dw rounded down to whole lines.
- R10: A write is unaligned when the three enables and the R5/R6 conditions hold but the address is off a line boundary. Such a write gets cmd 0x7 with length min(remain_bytes/4, fifo_bytes/4, Dwords to the next line boundary, max_burst_dw).
- R11: Any other write gets cmd 0x7 with length min(remain_bytes/4, fifo_bytes/4, max_burst_dw).
- R12: A read is line-eligible when line_size_en is 1, the R5, R6 and R8 conditions hold, and remain_bytes/4 is at least line_size_dw. A line-eligible read gets 0xC (read multiple) if rd_mult_en is 1, else 0xE (read line) if rd_line_en is 1, else 0x6. Every other read gets 0x6 (memory read).
- R13: A read burst length is min(remain_bytes/4, max_burst_dw).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Strobe requesting a decision for the next burst |
| done | input | 1 | Bus interface reports the current burst finished |
| is_write | input | 1 | 1 for a write burst, 0 for a read burst |
| line_size_en | input | 1 | Cache line size use enabled |
| dev_inv_en | input | 1 | Device-level write-and-invalidate enable |
| bus_inv_en | input | 1 | Write-and-invalidate enable from the PCI command register |
| rd_line_en | input | 1 | Read line mode enable |
| rd_mult_en | input | 1 | Read multiple mode enable |
| line_size_dw | input | CLS_W (8) | Cache line size in Dwords |
| max_burst_dw | input | LEN_W (8) | Programmed maximum burst in Dwords |
| addr | input | ADDR_W (32) | Current byte address |
| remain_bytes | input | CNT_W (24) | Bytes left in the transfer |
| fifo_bytes | input | FIFO_W (12) | Bytes held in the DMA FIFO |
| busy | output | 1 | A burst decision is held |
| cmd | output | 4 | PCI bus command code |
| burst_dw | output | LEN_W (8) | Burst length in Dwords |

## Verification
Command, length and busy all come from one register stage. They are due at the first rising edge after start is seen, and busy drops at the first rising edge after done. The bench changes inputs on falling edges, holds start or done for exactly one rising edge, and reads the outputs on the next falling edge. Each value is therefore read one full edge after it was loaded. During a held burst, the bench scrambles every decision input and pulses start again. It then reads the outputs one edge later, to show that nothing moved.

// File: rtl/pci_cmd_pkg.sv
package pci_cmd_pkg;

   typedef enum logic [3:0] {
      CMD_IDLE    = 4'h0,
      CMD_MEM_RD  = 4'h6,
      CMD_MEM_WR  = 4'h7,
      CMD_RD_MULT = 4'hC,
      CMD_RD_LINE = 4'hE,
      CMD_WR_INV  = 4'hF
   } pci_cmd_e;

   typedef struct packed {
      logic line_en;
      logic dev_inv;
      logic bus_inv;
      logic rd_line;
      logic rd_mult;
   } sel_mode_t;

   function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/pci_line_size_check.sv
module pci_line_size_check #(
   parameter int CLS_W     = 8,
   parameter int LOG2_MIN  = 1,
   parameter int LOG2_MAX  = 7
) (
   input  logic [CLS_W-1:0] line_size,
   output logic             legal,
   output logic [CLS_W-1:0] mask
);
   localparam int N_SIZES = LOG2_MAX - LOG2_MIN + 1;

   logic [N_SIZES-1:0] hit;

   for (genvar g = 0; g < N_SIZES; g++) begin : g_size
      assign hit[g] = (line_size == (CLS_W'(1) << (g + LOG2_MIN)));
   end

   assign legal = |hit;
   assign mask  = line_size - CLS_W'(1);

   always_comb begin
      assert ($onehot0(hit)) else $error("a_r5_single_size: several sizes matched");
   end

endmodule

// File: rtl/pci_cmd_decide.sv
module pci_cmd_decide
   import pci_cmd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24,
   parameter int FIFO_W = 12,
   parameter int CLS_W  = 8,
   parameter int LEN_W  = 8
) (
   input  logic              is_write,
   input  sel_mode_t         mode,
   input  logic [CLS_W-1:0]  line_size,
   input  logic              size_legal,
   input  logic [CLS_W-1:0]  size_mask,
   input  logic [LEN_W-1:0]  max_burst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  remain_bytes,
   input  logic [FIFO_W-1:0] fifo_bytes,
   output pci_cmd_e          cmd,
   output logic [LEN_W-1:0]  len
);
   logic [31:0] rem_dw, fifo_dw, cls32, mask32, mb32, addr_dw;
   logic [31:0] offs, to_bnd, avail, len32;
   logic        aligned, line_ok, inv_on, rd_line_ok;

   assign rem_dw  = 32'(remain_bytes) >> 2;
   assign fifo_dw = 32'(fifo_bytes) >> 2;
   assign addr_dw = 32'(addr) >> 2;
   assign cls32   = 32'(line_size);
   assign mask32  = 32'(size_mask);
   assign mb32    = 32'(max_burst);

   assign offs    = addr_dw & mask32;
   assign aligned = (offs == 32'd0);
   assign to_bnd  = cls32 - offs;
   assign avail   = umin(rem_dw, fifo_dw);

   assign line_ok    = size_legal && (cls32 <= mb32);
   assign inv_on     = mode.line_en && mode.dev_inv && mode.bus_inv;
   assign rd_line_ok = mode.line_en && line_ok && aligned && (rem_dw >= cls32);

   always_comb begin
      cmd   = CMD_MEM_WR;
      len32 = '0;
      if (is_write) begin
         if (inv_on && line_ok && aligned && fifo_dw >= cls32 && rem_dw >= cls32) begin
            cmd   = CMD_WR_INV;
            len32 = umin(avail & ~mask32, mb32 & ~mask32);
         end else if (inv_on && line_ok && !aligned) begin
            cmd   = CMD_MEM_WR;
            len32 = umin(umin(avail, to_bnd), mb32);
         end else begin
            cmd   = CMD_MEM_WR;
            len32 = umin(avail, mb32);
         end
      end else begin
         len32 = umin(rem_dw, mb32);
         if (rd_line_ok && mode.rd_mult)      cmd = CMD_RD_MULT;
         else if (rd_line_ok && mode.rd_line) cmd = CMD_RD_LINE;
         else                                 cmd = CMD_MEM_RD;
      end
   end

   assign len = LEN_W'(len32);

endmodule

// File: rtl/pci_cmd_hold.sv
module pci_cmd_hold
   import pci_cmd_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             done,
   input  pci_cmd_e         cmd_in,
   input  logic [LEN_W-1:0] len_in,
   output logic             busy,
   output pci_cmd_e         cmd_q,
   output logic [LEN_W-1:0] len_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cmd_q <= CMD_IDLE;
         len_q <= '0;
      end else if (busy) begin
         if (done) busy <= 1'b0;
      end else if (start) begin
         busy  <= 1'b1;
         cmd_q <= cmd_in;
         len_q <= len_in;
      end
   end

   a_r2_take: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && $stable(cmd_q) && $stable(len_q)));

   a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |=> (!busy && $stable(cmd_q) && $stable(len_q)));

endmodule

// File: rtl/pci_cmd_select.sv
module pci_cmd_select
   import pci_cmd_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int CNT_W         = 24,
   parameter int FIFO_W        = 12,
   parameter int CLS_W         = 8,
   parameter int LEN_W         = 8,
   parameter int LINE_LOG2_MIN = 1,
   parameter int LINE_LOG2_MAX = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              done,
   input  logic              is_write,
   input  logic              line_size_en,
   input  logic              dev_inv_en,
   input  logic              bus_inv_en,
   input  logic              rd_line_en,
   input  logic              rd_mult_en,
   input  logic [CLS_W-1:0]  line_size_dw,
   input  logic [LEN_W-1:0]  max_burst_dw,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  remain_bytes,
   input  logic [FIFO_W-1:0] fifo_bytes,
   output logic              busy,
   output logic [3:0]        cmd,
   output logic [LEN_W-1:0]  burst_dw
);
   if (ADDR_W > 32 || CNT_W > 32 || FIFO_W > 32 || LEN_W > 31) begin : g_bad_width
      initial $fatal(1, "pci_cmd_select: a width exceeds 32 bits");
   end
   if (LINE_LOG2_MIN < 1 || LINE_LOG2_MIN > LINE_LOG2_MAX || LINE_LOG2_MAX >= CLS_W) begin : g_bad_size
      initial $fatal(1, "pci_cmd_select: line size range does not fit CLS_W");
   end

   sel_mode_t        mode;
   logic             size_legal;
   logic [CLS_W-1:0] size_mask;
   pci_cmd_e         cmd_d, cmd_q;
   logic [LEN_W-1:0] len_d;

   assign mode = '{line_en: line_size_en, dev_inv: dev_inv_en, bus_inv: bus_inv_en,
                   rd_line: rd_line_en,   rd_mult: rd_mult_en};

   pci_line_size_check #(
      .CLS_W(CLS_W), .LOG2_MIN(LINE_LOG2_MIN), .LOG2_MAX(LINE_LOG2_MAX)
   ) u_size (
      .line_size (line_size_dw),
      .legal     (size_legal),
      .mask      (size_mask)
   );

   pci_cmd_decide #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIFO_W(FIFO_W), .CLS_W(CLS_W), .LEN_W(LEN_W)
   ) u_decide (
      .is_write     (is_write),
      .mode         (mode),
      .line_size    (line_size_dw),
      .size_legal   (size_legal),
      .size_mask    (size_mask),
      .max_burst    (max_burst_dw),
      .addr         (addr),
      .remain_bytes (remain_bytes),
      .fifo_bytes   (fifo_bytes),
      .cmd          (cmd_d),
      .len          (len_d)
   );

   pci_cmd_hold #(.LEN_W(LEN_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .done   (done),
      .cmd_in (cmd_d),
      .len_in (len_d),
      .busy   (busy),
      .cmd_q  (cmd_q),
      .len_q  (burst_dw)
   );

   assign cmd = cmd_q;

   a_r4_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && is_write && !(line_size_en && dev_inv_en && bus_inv_en))
      |=> (cmd == 4'h7));

   a_r12_read_family: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !is_write) |=> (cmd == 4'h6 || cmd == 4'hC || cmd == 4'hE));

   a_r13_read_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !is_write) |=> (burst_dw <= $past(max_burst_dw)));

   a_r9_inv_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd == 4'hF) |-> (burst_dw != '0));

endmodule

// File: tb/pci_cmd_select_tb.sv
`timescale 1ns/1ps
module pci_cmd_select_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, done = 1'b0, is_write = 1'b0;
   logic        le = 1'b0, de = 1'b0, be = 1'b0, rl = 1'b0, rm = 1'b0;
   logic [7:0]  cls = '0, mb = '0;
   logic [31:0] addr = '0;
   logic [23:0] rem = '0;
   logic [11:0] fifo = '0;
   logic        busy;
   logic [3:0]  cmd;
   logic [7:0]  blen;

   int n_chk = 0, n_err = 0;

   always #2 clk = ~clk;

   pci_cmd_select u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .is_write(is_write),
      .line_size_en(le), .dev_inv_en(de), .bus_inv_en(be), .rd_line_en(rl), .rd_mult_en(rm),
      .line_size_dw(cls), .max_burst_dw(mb), .addr(addr), .remain_bytes(rem),
      .fifo_bytes(fifo), .busy(busy), .cmd(cmd), .burst_dw(blen)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int mn(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   function automatic void ref_model(output int c, output int l, output string tag);
      int  s, r, f, m, off;
      bit  legal, lok, inv, al, ok;
      s = int'(cls); m = int'(mb);
      r = int'(rem) / 4; f = int'(fifo) / 4;
      legal = 0;
      for (int k = 1; k <= 7; k++) if (s == (1 << k)) legal = 1;
      off = legal ? int'((addr >> 2) % s) : 1;
      al  = legal && off == 0;
      lok = legal && s <= m;
      inv = le && de && be;
      if (is_write) begin
         if (inv && lok && al && f >= s && r >= s) begin
            c = 15; l = mn((mn(r, f) / s) * s, (m / s) * s); tag = "R9";
         end else if (inv && lok && !al) begin
            c = 7; l = mn(mn(mn(r, f), s - off), m); tag = "R10";
         end else begin
            c = 7; l = mn(mn(r, f), m); tag = "R11";
         end
      end else begin
         ok = le && lok && al && r >= s;
         c = ok ? (rm ? 12 : (rl ? 14 : 6)) : 6;
         l = mn(r, m); tag = "R12";
      end
   endfunction

   task automatic burst(input string tag_override);
      int ec, el, c0, l0;
      string tag;
      ref_model(ec, el, tag);
      if (tag_override != "") tag = tag_override;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 busy", int'(busy), 1);
      chk(tag, int'(cmd), ec);
      chk(is_write ? tag : "R13", int'(blen), el);
      c0 = int'(cmd); l0 = int'(blen);
      is_write = ~is_write; addr = $urandom; rem = 24'($urandom);
      fifo = 12'($urandom); cls = 8'($urandom); mb = 8'($urandom);
      {le, de, be, rl, rm} = 5'($urandom);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 hold cmd", int'(cmd), c0);
      chk("R2 hold len", int'(blen), l0);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk("R3 busy", int'(busy), 0);
      chk("R3 cmd kept", int'(cmd), c0);
   endtask

   task automatic setw(input bit w, input bit a, input bit b, input bit c,
                       input int s, input int m, input int ad, input int r, input int f);
      is_write = w; le = a; de = b; be = c; rl = 1'b1; rm = 1'b1;
      cls = 8'(s); mb = 8'(m); addr = 32'(ad); rem = 24'(r); fifo = 12'(f);
   endtask

   initial begin
      void'($urandom(32'h5EED_0420));
      repeat (3) @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 cmd", int'(cmd), 0);
      chk("R1 len", int'(blen), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle", int'(busy), 0);

      setw(1, 1, 1, 1, 8, 16, 32'h100, 400, 400); burst("R9");
      setw(1, 0, 1, 1, 8, 16, 32'h100, 400, 400); burst("R4");
      setw(1, 1, 0, 1, 8, 16, 32'h100, 400, 400); burst("R4");
      setw(1, 1, 1, 0, 8, 16, 32'h100, 400, 400); burst("R4");
      setw(1, 1, 1, 1, 6, 16, 32'h100, 400, 400); burst("R5");
      setw(1, 1, 1, 1, 128, 255, 32'h0, 4000, 4000); burst("R5");
      setw(1, 1, 1, 1, 32, 16, 32'h0, 400, 400); burst("R6");
      setw(1, 1, 1, 1, 8, 16, 32'h0, 400, 28); burst("R7");
      setw(1, 1, 1, 1, 8, 16, 32'h0, 28, 400); burst("R7");
      setw(1, 1, 1, 1, 8, 16, 32'h23, 400, 400); burst("R8");
      setw(1, 1, 1, 1, 8, 16, 32'h14, 400, 400); burst("R10");
      setw(1, 1, 1, 1, 4, 10, 32'h40, 400, 400); burst("R9");
      setw(1, 0, 0, 0, 8, 16, 32'h14, 400, 6); burst("R11");
      setw(0, 1, 0, 0, 8, 16, 32'h40, 400, 0); burst("R12");
      rm = 1'b0; burst("R12");
      rl = 1'b0; burst("R12");
      setw(0, 1, 0, 0, 8, 16, 32'h44, 400, 0); burst("R12");
      setw(0, 1, 0, 0, 8, 16, 32'h40, 20, 0); burst("R13");

      for (int i = 0; i < 400; i++) begin
         is_write = 1'($urandom);
         le = ($urandom % 5) != 0; de = ($urandom % 5) != 0; be = ($urandom % 5) != 0;
         rl = 1'($urandom); rm = 1'($urandom);
         cls = ($urandom % 4 != 0) ? 8'(2 << ($urandom % 7)) : 8'($urandom);
         mb  = ($urandom % 2 != 0) ? 8'(2 << ($urandom % 7)) : 8'($urandom);
         addr = $urandom;
         if ($urandom % 2 != 0) addr = addr & ~((32'(cls) << 2) - 32'd1);
         rem  = 24'($urandom % 2048);
         fifo = 12'($urandom);
         burst("");
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end
endmodule